// File: doc/BRIEF.md
# Four-Phase Handshake Sequencer

This block is a control element that serialises two (by default) downstream handshakes inside one upstream handshake. An upstream partner raises an activation request; the block then drives a complete four-phase, return-to-zero handshake on its first downstream port. Only when that handshake is back at rest does it drive the second port the same way. Once every downstream handshake has finished, it acknowledges the activation. When the upstream partner withdraws its request, the block releases the acknowledge and is ready to be activated again.

Each port is a plain request/acknowledge pair and carries no data, so no valid/ready stream interface applies. All inputs are sampled on one clock. Every channel rests with both wires low, and the active side always starts a cycle: request up, acknowledge up, request down, acknowledge down. The number of downstream ports is the parameter `N_SUB`. They are served strictly in index order.

Top module: `hs_seq`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `act_ack` and every bit of `sub_req` are 0.
- R2: While no activation is in progress (`act_req` low and `act_ack` low), every bit of `sub_req` stays 0.
- R3: When `act_req` is sampled high in the idle state, `sub_req[0]` is 1 after that same edge.
- R4: A downstream request that is high stays high until its acknowledge is sampled high, and it falls after that edge. The port is then finished only once its acknowledge has been sampled low again.
- R5: At most one downstream port is active at any time. A port's request rises only while every downstream request and acknowledge is low.
- R6: `act_ack` rises after the edge at which the acknowledge of the last port (index `N_SUB-1`) is sampled low after its request fell, and never earlier.
- R7: `act_ack` stays high while `act_req` is high. It falls after the first edge at which `act_req` is sampled low. After that the block is idle and accepts a new activation.
- R8: Within one activation, port k+1 is requested after the edge at which port k's acknowledge is sampled low, so the ports run in ascending index order, each exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| act_req | input | 1 | Activation request from the upstream (active) partner |
| act_ack | output | 1 | Activation acknowledge, completion of the whole sequence |
| sub_req | output | N_SUB | Request to each downstream (passive) partner |
| sub_ack | input | N_SUB | Acknowledge from each downstream partner |

## Verification
The embedded properties check on every cycle that no two downstream ports are requested at once and that a request never falls without an acknowledge. They also check that requests start only after the previous port returned to rest, that downstream activity happens only inside an open activation, and that the upstream acknowledge is held and released per protocol. Exact edge timing, completeness of the index order, and recovery after a reset in the middle of a sequence are shown only by the bench. There, a cycle-by-cycle model is compared against the outputs, with responders that react after random delays of 0 to 7 cycles and with varied upstream gap and hold times.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;
  typedef enum logic [1:0] {
    CTL_IDLE,
    CTL_RUN,
    CTL_HOLD
  } ctl_state_t;

  typedef enum logic [1:0] {
    LEG_REST,
    LEG_RAISED,
    LEG_RETURN
  } leg_state_t;
endpackage

// File: rtl/hs_seq_leg.sv
module hs_seq_leg
  import hs_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ack,
  output logic req,
  output logic done,
  output logic busy
);
  leg_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= LEG_REST;
      req <= 1'b0;
    end else begin
      case (st)
        LEG_REST: if (start) begin
          st  <= LEG_RAISED;
          req <= 1'b1;
        end
        LEG_RAISED: if (ack) begin
          st  <= LEG_RETURN;
          req <= 1'b0;
        end
        LEG_RETURN: if (!ack) st <= LEG_REST;
        default: begin
          st  <= LEG_REST;
          req <= 1'b0;
        end
      endcase
    end
  end

  // return-to-zero completes when the partner's acknowledge is seen low
  assign done = (st == LEG_RETURN) && !ack;
  assign busy = (st != LEG_REST);

  // R4: a request only starts from a rested channel
  p_rise_rested_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> !$past(ack));
  // R4: a request is withdrawn only after its acknowledge was seen
  p_fall_after_ack_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(req) |-> $past(ack));
endmodule

// File: rtl/hs_seq_ctl.sv
module hs_seq_ctl
  import hs_seq_pkg::*;
#(
  parameter int N_SUB = 2,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_req,
  output logic             act_ack,
  input  logic [N_SUB-1:0] leg_done,
  output logic [N_SUB-1:0] leg_start
);
  ctl_state_t       st;
  logic [IDX_W-1:0] idx;
  logic             last;
  logic             cur_done;

  assign last     = (idx == IDX_W'(N_SUB - 1));
  assign cur_done = leg_done[idx];

  for (genvar g = 0; g < N_SUB; g++) begin : g_start
    if (g == 0) begin : g_first
      assign leg_start[g] = (st == CTL_IDLE) && act_req;
    end else begin : g_next
      assign leg_start[g] = (st == CTL_RUN) && cur_done && !last &&
                            (idx == IDX_W'(g - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= CTL_IDLE;
      idx     <= '0;
      act_ack <= 1'b0;
    end else begin
      case (st)
        CTL_IDLE: if (act_req) begin
          st  <= CTL_RUN;
          idx <= '0;
        end
        CTL_RUN: if (cur_done) begin
          if (last) begin
            st      <= CTL_HOLD;
            act_ack <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        CTL_HOLD: if (!act_req) begin
          st      <= CTL_IDLE;
          act_ack <= 1'b0;
        end
        default: begin
          st      <= CTL_IDLE;
          act_ack <= 1'b0;
        end
      endcase
    end
  end

  // R7: acknowledge persists while the upstream request persists
  p_ack_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (act_ack && act_req) |=> act_ack);
  // R7: acknowledge is released only after the request was withdrawn
  p_ack_release_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(act_ack) |-> !$past(act_req));
  // R5: the controller never launches two legs at once
  p_single_start_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(leg_start));
endmodule

// File: rtl/hs_seq.sv
module hs_seq #(
  parameter int N_SUB = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_req,
  output logic             act_ack,
  output logic [N_SUB-1:0] sub_req,
  input  logic [N_SUB-1:0] sub_ack
);
  localparam int IDX_W = (N_SUB > 1) ? $clog2(N_SUB) : 1;

  logic [N_SUB-1:0] leg_start;
  logic [N_SUB-1:0] leg_done;
  logic [N_SUB-1:0] leg_busy;

  hs_seq_ctl #(.N_SUB(N_SUB), .IDX_W(IDX_W)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .act_req   (act_req),
    .act_ack   (act_ack),
    .leg_done  (leg_done),
    .leg_start (leg_start)
  );

  for (genvar g = 0; g < N_SUB; g++) begin : g_leg
    hs_seq_leg u_leg (
      .clk   (clk),
      .rst   (rst),
      .start (leg_start[g]),
      .ack   (sub_ack[g]),
      .req   (sub_req[g]),
      .done  (leg_done[g]),
      .busy  (leg_busy[g])
    );
  end

  // R1: reset clears every output on the following edge
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (sub_req == '0) && !act_ack);
  // R2: downstream activity only inside an open activation
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (|sub_req) |-> (act_req && !act_ack));
  // R5: no two downstream handshakes overlap
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(leg_busy));
  // R3: the first port is requested only in answer to an activation
  p_first_launch_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sub_req[0]) |-> ($past(act_req) && !$past(act_ack)));
  // R6: completion is raised with all downstream ports at rest
  p_ack_after_all_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(act_ack) |-> ($past(sub_req) == '0) && ($past(sub_ack) == '0));

  for (genvar g = 1; g < N_SUB; g++) begin : g_order
    // R8: port g starts right after port g-1 finished its return phase
    p_in_order_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(sub_req[g]) |-> ($past(leg_busy[g-1]) && !$past(sub_ack[g-1])));
  end
endmodule

// File: tb/hs_seq_bench.sv
module hs_seq_bench;
  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         act_req = 1'b0;
  logic         act_ack;
  logic [N-1:0] sub_req;
  logic [N-1:0] sub_ack = '0;

  always #4 clk = ~clk;

  hs_seq #(.N_SUB(N)) u_hs_seq (
    .clk(clk), .rst(rst), .act_req(act_req), .act_ack(act_ack),
    .sub_req(sub_req), .sub_ack(sub_ack)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural reference: phase 0 idle, 1 running a port, 2 holding ack
  int m_phase = 0;
  int m_idx   = 0;
  bit m_up    = 0;
  bit m_ack   = 0;

  int           dly [N];
  logic [N-1:0] prev_req = '0;
  int           next_port = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model_req();
    logic [N-1:0] r = '0;
    if (m_phase == 1 && m_up) r[m_idx] = 1'b1;
    return r;
  endfunction

  task automatic model_step();
    if (rst) begin
      m_phase = 0; m_idx = 0; m_up = 0; m_ack = 0;
    end else if (m_phase == 0) begin
      if (act_req) begin m_phase = 1; m_idx = 0; m_up = 1; end
    end else if (m_phase == 1) begin
      if (m_up) begin
        if (sub_ack[m_idx]) m_up = 0;
      end else if (!sub_ack[m_idx]) begin
        if (m_idx == N - 1) begin m_phase = 2; m_ack = 1; end
        else begin m_idx++; m_up = 1; end
      end
    end else begin
      if (!act_req) begin m_phase = 0; m_ack = 0; end
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(act_ack === m_ack, "R6 R7 act_ack", act_ack, m_ack);
    chk(sub_req === model_req(), "R3 R4 R5 sub_req", sub_req, model_req());
    if (!rst) begin
      for (int i = 0; i < N; i++) begin
        if (sub_req[i] && !prev_req[i]) begin
          chk(i == next_port, "R8 port order", i, next_port);
          chk(((sub_req & ~(N'(1) << i)) == '0) && (sub_ack == '0),
              "R5 launch on rested channels", {sub_req, sub_ack}, N'(1) << i);
          next_port++;
        end
      end
      if (act_ack) next_port = 0;
    end
    prev_req = sub_req;
    // passive partners answer after 0..7 cycles
    for (int i = 0; i < N; i++) begin
      if (rst) begin
        dly[i] = -1;
      end else if (sub_req[i] != sub_ack[i]) begin
        if (dly[i] < 0) dly[i] = $urandom_range(0, 7);
        if (dly[i] == 0) begin sub_ack[i] = sub_req[i]; dly[i] = -1; end
        else dly[i]--;
      end else begin
        dly[i] = -1;
      end
    end
  endtask

  task automatic activation(input int gap, input int hold);
    for (int k = 0; k < gap; k++) begin
      cycle();
      chk(sub_req == '0, "R2 quiet between activations", sub_req, 0);
    end
    act_req = 1'b1;
    cycle();
    chk(sub_req[0] === 1'b1, "R3 first port launch", sub_req, 1);
    while (act_ack !== 1'b1) cycle();
    for (int k = 0; k < hold; k++) begin
      cycle();
      chk(act_ack === 1'b1, "R7 ack held", act_ack, 1);
    end
    act_req = 1'b0;
    cycle();
    chk(act_ack === 1'b0, "R7 ack release", act_ack, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) dly[i] = -1;
    @(negedge clk);
    repeat (3) cycle();
    chk(act_ack === 1'b0 && sub_req === '0, "R1 reset state",
        {sub_req, act_ack}, 0);
    rst = 1'b0;
    for (int k = 0; k < 10; k++) begin
      cycle();
      chk(sub_req == '0 && act_ack == 1'b0, "R2 idle quiet", sub_req, 0);
    end
    for (int n = 0; n < 30; n++)
      activation($urandom_range(0, 5), $urandom_range(0, 5));
    // reset in the middle of a sequence
    act_req = 1'b1;
    repeat (4) cycle();
    rst = 1'b1; act_req = 1'b0; sub_ack = '0;
    repeat (2) cycle();
    chk(act_ack === 1'b0 && sub_req === '0, "R1 mid-sequence reset",
        {sub_req, act_ack}, 0);
    rst = 1'b0; prev_req = '0; next_port = 0;
    for (int n = 0; n < 20; n++)
      activation($urandom_range(0, 3), $urandom_range(0, 3));
    repeat (5) cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule